// File: doc/BRIEF.md
# Button-Stepped Power Load Sequencer

This block runs a power-measurement load from four active-low push buttons. It keeps two independent 2-bit settings. The first is an activity rate, made as a clock-enable pattern on one base clock. The second is a load level, which sets how many replicated load stamps run. Both settings appear on four LEDs. A bank of output pins, organised as one group per stamp, toggles at the activity rate. The pins toggle only while the hold button is pressed, and only in the groups whose stamp is switched on by the load level.

Each stamp is a small switching load. A pseudo-random lookup table feeds a multiplier, and a shift register takes in a bit that inverts on every active cycle. A stamp that is switched off, and a pin group that is gated, keep their last value, so they add no switching activity. Each button is synchronised and debounced before use. A press is counted once, on the debounced transition from released to pressed.

Top module: `pwrdemo_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the LEDs read 0000, every pin and every stamp result is 0, and no stamp enable is asserted.
- R2: Each debounced press of button 1 (`btn_n[1]`) steps the rate code by one, wrapping from 11 to 00. The rate code is shown on `led[1]` (MSB) and `led[0]` (LSB).
- R3: Each debounced press of button 2 (`btn_n[2]`) steps the load code by one, wrapping from 11 to 00. The load code is shown on `led[3]` (MSB) and `led[2]` (LSB).
- R4: A debounced press of button 0 (`btn_n[0]`) clears both codes to 00.
- R5: A button held down for any length of time gives exactly one step.
- R6: A low level on a button that lasts fewer than `DB_CYCLES` synchronised samples has no effect.
- R7: The activity enable follows a mod-3 phase that starts at 0 after reset. It is never asserted for rate code 00. For code 01 it is asserted in phase 0, for code 10 in phases 0 and 1, and for code 11 in every cycle.
- R8: `stamp_en[k]` is high exactly when the activity enable is high and the load code is at least k. Stamp 0 is therefore always included.
- R9: Pin group g is `pin_out[g*PINS_PER_STAMP +: PINS_PER_STAMP]`. All of its bits invert together on each active cycle while button 3 (`btn_n[3]`) is held and g is not above the load code. This gives 16, 32, 48 and 64 toggling pins for load codes 00 to 11.
- R10: While button 3 is released, or while the activity enable is low, no pin changes.
- R11: A stamp whose enable is low keeps its result unchanged. An enabled stamp changes its result over a run of active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 4 | Raw push buttons, active low: [0] clear, [1] rate step, [2] load step, [3] output hold |
| led | output | 4 | {load code, rate code} |
| stamp_en | output | 4 | Per-stamp activity enables |
| pin_out | output | 4*PINS_PER_STAMP | Toggling output pin groups, one group per stamp |
| stamp_dout | output | 4*2*DATA_W | Concatenated stamp results, stamp k at bits [k*2*DATA_W +: 2*DATA_W] |

## Verification
The hardest state to reach is the full pin activity check. It needs the hold button to be debounced and held while the load code sits at each level and the rate code sits at 11, and it needs short glitches to be seen alongside genuine long presses. The stimulus first steps the rate code through every value and back to 11 through real debounced presses. It then walks the load code from 00 to 11 and wraps it back, and at each level it presses and releases the hold button. A reference model in the bench tracks the debounce timing, the mod-3 phase and the pin toggles from the raw button samples alone, and is compared against the outputs on every clock.

// File: rtl/pwrdemo_pkg.sv
package pwrdemo_pkg;

    localparam int NUM_STAMPS = 4;
    localparam int NUM_BTN    = 4;
    localparam int BTN_CLR    = 0;
    localparam int BTN_FREQ   = 1;
    localparam int BTN_RES    = 2;
    localparam int BTN_HOLD   = 3;

    typedef enum logic [1:0] {
        RATE_OFF        = 2'b00,
        RATE_THIRD      = 2'b01,
        RATE_TWO_THIRDS = 2'b10,
        RATE_FULL       = 2'b11
    } rate_code_t;

    // Packed so that the struct maps straight onto the LED vector.
    typedef struct packed {
        logic [1:0] res;
        rate_code_t freq;
    } demo_state_t;

    typedef struct packed {
        logic clr;
        logic freq;
        logic res;
    } step_req_t;

    function automatic logic rate_fire(rate_code_t code, logic [1:0] phase);
        case (code)
            RATE_OFF:        return 1'b0;
            RATE_THIRD:      return phase == 2'd0;
            RATE_TWO_THIRDS: return phase != 2'd2;
            default:         return 1'b1;
        endcase
    endfunction

    // Pseudo-random table content, computed from the seed and the address.
    function automatic logic [15:0] rom_word(logic [15:0] seed, logic [15:0] addr);
        logic [15:0] x;
        x = 16'hACE1 ^ (seed * 16'h1F35) ^ (addr * 16'h0F5B);
        for (int i = 0; i < 5; i++) begin
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
        end
        return x;
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int DB_CYCLES   = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit HOLD_MODE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic sig
);
    localparam int CW = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;
    logic                   differs;
    logic                   at_last;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
    end

    assign differs = sync_q[SYNC_STAGES-1] != level_q;
    assign at_last = cnt_q == LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else if (!differs) begin
            cnt_q <= '0;
        end else if (at_last) begin
            level_q <= sync_q[SYNC_STAGES-1];
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold mode reports the debounced pressed level; edge mode a one-cycle press pulse.
    assign sig = HOLD_MODE ? ~level_q : (differs & at_last & level_q);

endmodule

// File: rtl/rate_gen.sv
module rate_gen
    import pwrdemo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rate_code_t code,
    output logic       fire
);
    logic [1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                  phase_q <= 2'd0;
        else if (phase_q == 2'd2) phase_q <= 2'd0;
        else                      phase_q <= phase_q + 2'd1;
    end

    assign fire = rate_fire(code, phase_q);

endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import pwrdemo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  step_req_t   req,
    output demo_state_t st
);
    always_ff @(posedge clk) begin
        if (rst || req.clr) begin
            st <= '{res: 2'd0, freq: RATE_OFF};
        end else begin
            if (req.freq) st.freq <= rate_code_t'(st.freq + 2'd1);
            if (req.res)  st.res  <= st.res + 2'd1;
        end
    end

endmodule

// File: rtl/load_stamp.sv
module load_stamp
    import pwrdemo_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          ROM_AW = 4,
    parameter logic [15:0] SEED   = 16'h0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [2*DATA_W-1:0] dout
);
    localparam int OW = 2 * DATA_W;

    logic [ROM_AW-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [OW-1:0]     prod_q;
    logic [OW-1:0]     sr_q;
    logic              tog_q;
    logic [15:0]       word_a;
    logic [15:0]       word_b;

    assign word_a = rom_word(SEED, 16'(addr_q));
    assign word_b = rom_word(SEED, 16'(~addr_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            prod_q <= '0;
            sr_q   <= '0;
            tog_q  <= 1'b0;
        end else if (en) begin
            addr_q <= addr_q + 1'b1;
            data_q <= word_a[DATA_W-1:0];
            prod_q <= data_q * word_b[DATA_W-1:0];
            tog_q  <= ~tog_q;
            sr_q   <= {sr_q[OW-2:0], tog_q};
        end
    end

    assign dout = prod_q ^ sr_q;

endmodule

// File: rtl/pwrdemo_ctrl.sv
module pwrdemo_ctrl
    import pwrdemo_pkg::*;
#(
    parameter int PINS_PER_STAMP = 16,
    parameter int DB_CYCLES      = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int DATA_W         = 8,
    parameter int ROM_AW         = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_BTN-1:0]                     btn_n,
    output logic [3:0]                             led,
    output logic [NUM_STAMPS-1:0]                  stamp_en,
    output logic [NUM_STAMPS*PINS_PER_STAMP-1:0]   pin_out,
    output logic [NUM_STAMPS*2*DATA_W-1:0]         stamp_dout
);
    localparam int DOUT_W = 2 * DATA_W;

    logic [NUM_BTN-1:0]    btn_sig;
    logic                  hold_on;
    logic                  fire;
    step_req_t             req;
    demo_state_t           st;
    logic [NUM_STAMPS-1:0] grp_q;

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        btn_conditioner #(
            .DB_CYCLES  (DB_CYCLES),
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD_MODE  (b == BTN_HOLD)
        ) u_btn (
            .clk  (clk),
            .rst  (rst),
            .raw_n(btn_n[b]),
            .sig  (btn_sig[b])
        );
    end

    assign req     = '{clr: btn_sig[BTN_CLR], freq: btn_sig[BTN_FREQ], res: btn_sig[BTN_RES]};
    assign hold_on = btn_sig[BTN_HOLD];

    step_ctrl u_step (
        .clk(clk),
        .rst(rst),
        .req(req),
        .st (st)
    );

    rate_gen u_rate (
        .clk (clk),
        .rst (rst),
        .code(st.freq),
        .fire(fire)
    );

    assign led = st;

    for (genvar k = 0; k < NUM_STAMPS; k++) begin : g_stamp
        assign stamp_en[k] = fire & (st.res >= 2'(k));

        load_stamp #(
            .DATA_W(DATA_W),
            .ROM_AW(ROM_AW),
            .SEED  (16'(16'h1357 * (k + 1)))
        ) u_stamp (
            .clk (clk),
            .rst (rst),
            .en  (stamp_en[k]),
            .dout(stamp_dout[k*DOUT_W +: DOUT_W])
        );

        always_ff @(posedge clk) begin
            if (rst)                        grp_q[k] <= 1'b0;
            else if (stamp_en[k] & hold_on) grp_q[k] <= ~grp_q[k];
        end

        assign pin_out[k*PINS_PER_STAMP +: PINS_PER_STAMP] = {PINS_PER_STAMP{grp_q[k]}};
    end

endmodule

// File: rtl/pwrdemo_chk.sv
module pwrdemo_chk #(
    parameter int PINS_PER_STAMP = 16,
    parameter int DATA_W         = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [3:0]                   led,
    input logic [3:0]                   stamp_en,
    input logic [4*PINS_PER_STAMP-1:0]  pin_out,
    input logic [4*2*DATA_W-1:0]        stamp_dout
);
    localparam int OW = 2 * DATA_W;

    p_freq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (led[1:0] != $past(led[1:0])) |-> ((led[1:0] == $past(led[1:0]) + 2'd1) || (led[1:0] == 2'd0)));

    p_res_step_r3: assert property (@(posedge clk) disable iff (rst)
        (led[3:2] != $past(led[3:2])) |-> ((led[3:2] == $past(led[3:2]) + 2'd1) || (led[3:2] == 2'd0)));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (led[1:0] == 2'd0) |-> (stamp_en == 4'd0));

    p_full_r7: assert property (@(posedge clk) disable iff (rst)
        (led[1:0] == 2'd3) |-> stamp_en[0]);

    p_pins_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !stamp_en[0] |=> $stable(pin_out));

    for (genvar k = 1; k < 4; k++) begin : g_nest
        p_nested_r8: assert property (@(posedge clk) disable iff (rst)
            stamp_en[k] |-> stamp_en[k-1]);
    end

    for (genvar k = 0; k < 4; k++) begin : g_hold
        p_stamp_hold_r11: assert property (@(posedge clk) disable iff (rst)
            !stamp_en[k] |=> $stable(stamp_dout[k*OW +: OW]));
    end

endmodule

bind pwrdemo_ctrl pwrdemo_chk #(
    .PINS_PER_STAMP(PINS_PER_STAMP),
    .DATA_W        (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .led       (led),
    .stamp_en  (stamp_en),
    .pin_out   (pin_out),
    .stamp_dout(stamp_dout)
);

// File: tb/tb_pwrdemo_ctrl.sv
module tb_pwrdemo_ctrl;
    localparam int DB   = 4;
    localparam int PPS  = 16;
    localparam int DW   = 8;
    localparam int OW   = 2 * DW;
    localparam int NPIN = 4 * PPS;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      btn_n = 4'hF;
    logic [3:0]      led;
    logic [3:0]      stamp_en;
    logic [NPIN-1:0] pin_out;
    logic [4*OW-1:0] stamp_dout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pwrdemo_ctrl #(
        .PINS_PER_STAMP(PPS),
        .DB_CYCLES     (DB),
        .DATA_W        (DW)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .btn_n     (btn_n),
        .led       (led),
        .stamp_en  (stamp_en),
        .pin_out   (pin_out),
        .stamp_dout(stamp_dout)
    );

    // Reference model, driven only by the raw button samples
    int         m_freq  = 0;
    int         m_res   = 0;
    int         m_phase = 0;
    bit         m_lvl[4] = '{1, 1, 1, 1};
    bit         m_pin[4] = '{0, 0, 0, 0};
    logic [3:0] hist[$];

    function automatic bit m_fire(int f, int ph);
        case (f)
            0:       return 1'b0;
            1:       return ph == 0;
            2:       return ph != 2;
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_freq = 0; m_res = 0; m_phase = 0;
            for (int b = 0; b < 4; b++) begin m_lvl[b] = 1; m_pin[b] = 0; end
        end else begin
            bit ce;
            bit pr[4];
            ce = m_fire(m_freq, m_phase);
            for (int g = 0; g < 4; g++)
                if (ce && !m_lvl[3] && g <= m_res) m_pin[g] = ~m_pin[g];
            for (int b = 0; b < 4; b++) begin
                bit flip;
                flip = hist.size() >= DB + 1;
                if (flip)
                    for (int i = 1; i <= DB; i++)
                        if (hist[hist.size()-1-i][b] == m_lvl[b]) flip = 0;
                pr[b] = flip && m_lvl[b];
                if (flip) m_lvl[b] = ~m_lvl[b];
            end
            if (pr[0]) begin
                m_freq = 0; m_res = 0;
            end else begin
                if (pr[1]) m_freq = (m_freq + 1) % 4;
                if (pr[2]) m_res  = (m_res + 1) % 4;
            end
            m_phase = (m_phase + 1) % 3;
        end
        hist.push_back(btn_n);
        if (hist.size() > 40) void'(hist.pop_front());
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Comparison against the model on every clock
    bit        p_en[4];
    logic [OW-1:0] p_dout[4];
    always @(negedge clk) begin
        if (!rst) begin
            check(led[1:0] == 2'(m_freq), "R2", "rate leds", led[1:0], m_freq);
            check(led[3:2] == 2'(m_res),  "R3", "load leds", led[3:2], m_res);
            for (int k = 0; k < 4; k++) begin
                bit e;
                e = m_fire(m_freq, m_phase) && (k <= m_res);
                check(stamp_en[k] == e, "R8", "stamp enable", stamp_en[k], e);
                check(pin_out[k*PPS +: PPS] == {PPS{m_pin[k]}}, "R9", "pin group",
                      pin_out[k*PPS +: PPS], {PPS{m_pin[k]}});
                if (!p_en[k])
                    check(stamp_dout[k*OW +: OW] == p_dout[k], "R11", "disabled stamp held",
                          stamp_dout[k*OW +: OW], p_dout[k]);
            end
        end
        for (int k = 0; k < 4; k++) begin
            p_en[k]   = stamp_en[k];
            p_dout[k] = stamp_dout[k*OW +: OW];
        end
    end

    task automatic press(int b, int hold);
        btn_n[b] = 1'b0;
        repeat (hold) @(negedge clk);
        btn_n[b] = 1'b1;
        repeat (DB + 8) @(negedge clk);
    endtask

    task automatic count_en(int cycles, int exp, string tag);
        int c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (stamp_en[0]) c++;
        end
        check(c == exp, tag, "activity count", c, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(led == 4'h0, "R1", "led after reset", led, 0);
        check(pin_out == '0, "R1", "pins after reset", pin_out, 0);
        check(stamp_en == 4'h0, "R1", "enables after reset", stamp_en, 0);
        check(stamp_dout == '0, "R1", "stamp results after reset", stamp_dout, 0);

        // R6 short glitch
        btn_n[1] = 1'b0;
        repeat (DB - 1) @(negedge clk);
        btn_n[1] = 1'b1;
        repeat (DB + 8) @(negedge clk);
        check(led[1:0] == 2'd0, "R6", "glitch ignored", led[1:0], 0);

        // R5 long hold gives a single step
        press(1, 25);
        check(led[1:0] == 2'd1, "R5", "one step per hold", led[1:0], 1);
        count_en(30, 10, "R7");
        press(1, 6);
        check(led[1:0] == 2'd2, "R2", "rate step", led[1:0], 2);
        count_en(30, 20, "R7");
        press(1, 6);
        count_en(30, 30, "R7");
        press(1, 6);
        check(led[1:0] == 2'd0, "R2", "rate wrap", led[1:0], 0);
        count_en(30, 0, "R7");
        for (int i = 0; i < 3; i++) press(1, 6);
        check(led[1:0] == 2'd3, "R2", "rate at full", led[1:0], 3);

        // R9 / R10 pin groups at each load level
        for (int r = 0; r < 4; r++) begin
            logic [NPIN-1:0] a, b2;
            int diff;
            check(stamp_en == 4'((1 << (r + 1)) - 1), "R8", "enable mask",
                  stamp_en, (1 << (r + 1)) - 1);
            btn_n[3] = 1'b0;
            repeat (DB + 6) @(negedge clk);
            a = pin_out;
            @(negedge clk);
            b2 = pin_out;
            diff = 0;
            for (int g = 0; g < 4; g++)
                if (a[g*PPS +: PPS] != b2[g*PPS +: PPS]) diff++;
            check(diff == r + 1, "R9", "toggling groups", diff, r + 1);
            btn_n[3] = 1'b1;
            repeat (DB + 6) @(negedge clk);
            a = pin_out;
            repeat (10) @(negedge clk);
            check(pin_out == a, "R10", "pins still when released", pin_out, a);
            press(2, 6);
            check(led[3:2] == 2'((r + 1) % 4), "R3", "load step", led[3:2], (r + 1) % 4);
        end

        // R11 stamps above the load code hold, stamp 0 keeps switching
        begin
            logic [4*OW-1:0] s;
            s = stamp_dout;
            repeat (20) @(negedge clk);
            for (int k = 1; k < 4; k++)
                check(stamp_dout[k*OW +: OW] == s[k*OW +: OW], "R11", "idle stamp held",
                      stamp_dout[k*OW +: OW], s[k*OW +: OW]);
            check(stamp_dout[OW-1:0] != s[OW-1:0], "R11", "active stamp switches",
                  stamp_dout[OW-1:0], s[OW-1:0]);
        end

        // R4 clear button
        press(2, 6);
        press(2, 6);
        check(led == 4'b1011, "R4", "before clear", led, 4'b1011);
        press(0, 6);
        check(led == 4'h0, "R4", "clear both codes", led, 0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule